// File: doc/BRIEF.md
# Extended I/O Interrupt Router

This block collects up to 256 device interrupt lines, latches each rising edge into a pending bit, and steers every pending, enabled vector to interrupt pins on the cores of the local node. Each vector has a route byte. Its upper nibble names a target node and its lower nibble is a bitmap of cores within that node. Each group of 32 vectors shares a pin-select byte, and that byte chooses which of the per-core CPU interrupt pins the group drives. A core pin is raised while any vector that routes to it is both pending and enabled.

Software reaches all state through a 64-bit register port with byte enables, so 32-bit accesses are byte-enable subsets of a doubleword. Pending status is cleared by writing ones. Two further arrays are kept only for software: a bounce mask with one bit per vector, and a node-map array. The vector count is a parameter (64, 128, 192 or 256), and every array scales with it.

Top module: `xirq_router`

## Requirements
- R1: After reset every configuration array (enable, bounce, node map, pin select, route) reads 0, all pending bits are 0 and `core_irq` is 0.
- R2: A 0-to-1 transition of `irq_in[v]` sets pending bit v, which reads back as bit v%64 of the doubleword at 0x1800 + 8*(v/64). A line that stays high does not set the bit again once it has been cleared.
- R3: A write to a pending doubleword clears each bit whose `reg_wdata` bit is 1 and whose byte lane has `reg_be` set. All other bits keep their value.
- R4: When a rising edge and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Enable bit for vector v is bit v%64 of the doubleword at 0x1600 + 8*(v/64), where 1 means enabled. A pending vector whose enable bit is 0 drives no pin and stays pending.
- R6: Route byte v is byte lane v%8 of the doubleword at 0x1C00 + 8*(v/8). Bits [7:4] hold the target node and bits [3:0] are a core bitmap. A vector drives pins only on cores whose bitmap bit is set, and only when the node field equals `node_id`.
- R7: Pin-select byte for group g = v/32 is byte lane g of the doubleword at 0x14C0. Core c's pin k is `core_irq[c*PINS+k]`, and a routed vector raises pin k when bit k of its group's byte is 1. A byte with several bits set raises several pins.
- R8: The bounce array (0x1680, same layout as enable) and the node-map array (0x14A0, NUM_VEC/8 bytes) store written bytes under byte enables and read them back unchanged.
- R9: Reads of any offset outside the six arrays return 0, and writes there change no readable state.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd` and is 0 in cycles that do not follow a read. `core_irq` reflects pending, enable and routing state one cycle after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 4 | Node number of this router |
| irq_in | input | NUM_VEC | Device interrupt lines, edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address, doubleword aligned (bits [2:0] ignored) |
| reg_wdata | input | 64 | Write data |
| reg_be | input | 8 | Byte-lane enables for writes |
| reg_rdata | output | 64 | Read data, one cycle after `reg_rd` |
| core_irq | output | CORES*PINS | Per-core interrupt pins, core c pin k at index c*PINS+k |

## Verification
Corrupted pending state surfaces at the ports in two ways. It shows on the next read of the status doubleword, and one cycle later as a pin that stays high after a clear or never rises after an edge. A routing or pin-select decode error shows as a wrong bit of `core_irq` within one cycle of the vector becoming pending. The bench therefore sweeps every vector of a 128-vector instance, each with its own route, enable and group pattern, and checks the status readback and the exact pin vector after each edge and after each clear.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   typedef logic [63:0] dword_t;

   localparam int unsigned ADDR_W = 13;

   // doubleword indices (byte address >> 3) of each array
   localparam logic [9:0] NMAP_BASE  = 10'h294;
   localparam logic [9:0] PSEL_BASE  = 10'h298;
   localparam logic [9:0] EN_BASE    = 10'h2C0;
   localparam logic [9:0] BNC_BASE   = 10'h2D0;
   localparam logic [9:0] PEND_BASE  = 10'h300;
   localparam logic [9:0] ROUTE_BASE = 10'h380;

   function automatic logic in_block(input logic [9:0] w, input logic [9:0] base,
                                     input int unsigned n);
      return (32'(w) >= 32'(base)) && (32'(w) < 32'(base) + n);
   endfunction

   function automatic logic [4:0] blk_ofs(input logic [9:0] w, input logic [9:0] base);
      logic [9:0] d;
      d = w - base;
      return d[4:0];
   endfunction
endpackage

// File: rtl/xirq_bytebank.sv
module xirq_bytebank
   import xirq_pkg::*;
#(
   parameter int unsigned NBYTES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [4:0]          widx,
   input  dword_t              wdata,
   input  logic [7:0]          be,
   output logic [NBYTES*8-1:0] bytes_o,
   output dword_t              rword
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bytes_o[b*8 +: 8] <= '0;
         else if (wr_en && widx == 5'(b / 8) && be[b % 8])
            bytes_o[b*8 +: 8] <= wdata[(b % 8)*8 +: 8];
      end
   end

   always_comb begin
      rword = '0;
      for (int l = 0; l < 8; l++) begin
         if (32'(widx) * 8 + 32'(l) < NBYTES)
            rword[l*8 +: 8] = bytes_o[(32'(widx) * 8 + 32'(l))*8 +: 8];
      end
   end
endmodule

// File: rtl/xirq_pending.sv
module xirq_pending
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_VEC = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] irq_in,
   input  logic               clr_en,
   input  logic [4:0]         widx,
   input  dword_t             wdata,
   input  logic [7:0]         be,
   output logic [NUM_VEC-1:0] pend_o
);
   localparam int unsigned NW = NUM_VEC / 64;

   logic [NUM_VEC-1:0] prev_q;
   logic [NUM_VEC-1:0] clr_mask;
   dword_t             lane_mask;

   always_comb begin
      for (int l = 0; l < 8; l++) lane_mask[l*8 +: 8] = {8{be[l]}};
      clr_mask = '0;
      for (int w = 0; w < NW; w++) begin
         if (clr_en && widx == 5'(w)) clr_mask[w*64 +: 64] = wdata & lane_mask;
      end
   end

   // a new edge is OR-ed in after the clear, so it survives a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_o <= '0;
      end else begin
         prev_q <= irq_in;
         pend_o <= (pend_o & ~clr_mask) | (irq_in & ~prev_q);
      end
   end
endmodule

// File: rtl/xirq_dispatch.sv
module xirq_dispatch #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned CORES   = 4,
   parameter int unsigned PINS    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3:0]              node_id,
   input  logic [NUM_VEC-1:0]      pend,
   input  logic [NUM_VEC-1:0]      en,
   input  logic [NUM_VEC*8-1:0]    route,
   input  logic [NUM_VEC/4-1:0]    psel,
   output logic [CORES*PINS-1:0]   core_irq
);
   localparam int unsigned NGRP = NUM_VEC / 32;

   logic [NUM_VEC-1:0]    live;
   logic [CORES*PINS-1:0] pin_d;

   always_comb begin
      for (int v = 0; v < NUM_VEC; v++)
         live[v] = pend[v] & en[v] & (route[v*8+4 +: 4] == node_id);
   end

   for (genvar c = 0; c < CORES; c++) begin : g_core
      logic [NUM_VEC-1:0] aim;
      logic [NGRP-1:0]    grp;
      always_comb begin
         for (int v = 0; v < NUM_VEC; v++) aim[v] = route[v*8 + c];
      end
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp[g] = |(live[g*32 +: 32] & aim[g*32 +: 32]);
      end
      for (genvar k = 0; k < PINS; k++) begin : g_pin
         logic [NGRP-1:0] sel;
         always_comb begin
            for (int g = 0; g < NGRP; g++) sel[g] = psel[g*8 + k];
         end
         assign pin_d[c*PINS + k] = |(grp & sel);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) core_irq <= '0;
      else        core_irq <= pin_d;
   end
endmodule

// File: rtl/xirq_router.sv
module xirq_router
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned CORES   = 4,
   parameter int unsigned PINS    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            node_id,
   input  logic [NUM_VEC-1:0]    irq_in,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [63:0]           reg_wdata,
   input  logic [7:0]            reg_be,
   output logic [63:0]           reg_rdata,
   output logic [CORES*PINS-1:0] core_irq
);
   localparam int unsigned NW64     = NUM_VEC / 64;
   localparam int unsigned NGRP     = NUM_VEC / 32;
   localparam int unsigned PSEL_NW  = (NGRP + 7) / 8;
   localparam int unsigned ROUTE_NW = NUM_VEC / 8;

   if (NUM_VEC % 64 != 0 || NUM_VEC < 64 || NUM_VEC > 256) begin : g_bad_vec
      $error("NUM_VEC must be 64, 128, 192 or 256");
   end
   if (CORES < 1 || CORES > 4) begin : g_bad_cores
      $error("CORES must be 1..4 (route bitmap is 4 bits)");
   end
   if (PINS < 1 || PINS > 8) begin : g_bad_pins
      $error("PINS must be 1..8 (pin-select byte is 8 bits)");
   end

   logic [9:0] word;
   assign word = reg_addr[ADDR_W-1:3];

   logic hit_nmap, hit_psel, hit_en, hit_bnc, hit_pend, hit_route;
   assign hit_nmap  = in_block(word, NMAP_BASE,  NW64);
   assign hit_psel  = in_block(word, PSEL_BASE,  PSEL_NW);
   assign hit_en    = in_block(word, EN_BASE,    NW64);
   assign hit_bnc   = in_block(word, BNC_BASE,   NW64);
   assign hit_pend  = in_block(word, PEND_BASE,  NW64);
   assign hit_route = in_block(word, ROUTE_BASE, ROUTE_NW);

   logic [NUM_VEC-1:0]   nmap_bytes, en_bits, bnc_bits, pend_q;
   logic [NGRP*8-1:0]    psel_bytes;
   logic [NUM_VEC*8-1:0] route_bytes;
   dword_t               nmap_rw, psel_rw, en_rw, bnc_rw, route_rw;

   xirq_bytebank #(.NBYTES(NUM_VEC/8)) u_nmap (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_nmap), .widx(blk_ofs(word, NMAP_BASE)),
      .wdata(reg_wdata), .be(reg_be), .bytes_o(nmap_bytes), .rword(nmap_rw));

   xirq_bytebank #(.NBYTES(NGRP)) u_psel (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_psel), .widx(blk_ofs(word, PSEL_BASE)),
      .wdata(reg_wdata), .be(reg_be), .bytes_o(psel_bytes), .rword(psel_rw));

   xirq_bytebank #(.NBYTES(NUM_VEC/8)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_en), .widx(blk_ofs(word, EN_BASE)),
      .wdata(reg_wdata), .be(reg_be), .bytes_o(en_bits), .rword(en_rw));

   xirq_bytebank #(.NBYTES(NUM_VEC/8)) u_bnc (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_bnc), .widx(blk_ofs(word, BNC_BASE)),
      .wdata(reg_wdata), .be(reg_be), .bytes_o(bnc_bits), .rword(bnc_rw));

   xirq_bytebank #(.NBYTES(NUM_VEC)) u_route (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_route), .widx(blk_ofs(word, ROUTE_BASE)),
      .wdata(reg_wdata), .be(reg_be), .bytes_o(route_bytes), .rword(route_rw));

   xirq_pending #(.NUM_VEC(NUM_VEC)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_en(reg_wr && hit_pend),
      .widx(blk_ofs(word, PEND_BASE)), .wdata(reg_wdata), .be(reg_be), .pend_o(pend_q));

   xirq_dispatch #(.NUM_VEC(NUM_VEC), .CORES(CORES), .PINS(PINS)) u_disp (
      .clk(clk), .rst_n(rst_n), .node_id(node_id), .pend(pend_q), .en(en_bits),
      .route(route_bytes), .psel(psel_bytes), .core_irq(core_irq));

   // software-only arrays and unused address bits
   logic unused_store;
   assign unused_store = ^{nmap_bytes, bnc_bits, reg_addr[2:0]};

   dword_t rmux;
   always_comb begin
      rmux = '0;
      if (hit_nmap)       rmux = nmap_rw;
      else if (hit_psel)  rmux = psel_rw;
      else if (hit_en)    rmux = en_rw;
      else if (hit_bnc)   rmux = bnc_rw;
      else if (hit_route) rmux = route_rw;
      else if (hit_pend) begin
         for (int w = 0; w < NW64; w++)
            if (blk_ofs(word, PEND_BASE) == 5'(w)) rmux = pend_q[w*64 +: 64];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_rdata <= '0;
      else        reg_rdata <= reg_rd ? rmux : '0;
   end
endmodule

// File: rtl/xirq_router_chk.sv
module xirq_router_chk #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned CORES   = 4,
   parameter int unsigned PINS    = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr,
   input logic                  reg_rd,
   input logic [12:0]           reg_addr,
   input logic [63:0]           reg_rdata,
   input logic [NUM_VEC-1:0]    irq_in,
   input logic [NUM_VEC-1:0]    pend,
   input logic [NUM_VEC-1:0]    en,
   input logic [CORES*PINS-1:0] core_irq
);
   logic [NUM_VEC-1:0] in_d;
   logic [NUM_VEC-1:0] rise;
   logic               pend_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_d <= '0;
      else        in_d <= irq_in;
   end
   assign rise    = irq_in & ~in_d;
   assign pend_wr = reg_wr && (reg_addr[12:3] >= 10'h300)
                    && (32'(reg_addr[12:3]) < 32'h300 + NUM_VEC / 64);

   // R2, R4: an edge always leaves its pending bit set
   a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((pend & $past(rise)) == $past(rise)));

   // R3: pending bits fall only after a write to the status array
   a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend) & ~pend)) |-> $past(pend_wr));

   // R5: a pin needs an enabled pending vector one cycle earlier
   a_r5_pin_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_irq) |-> $past(|(pend & en)));

   // R10: read data is zero unless a read was issued in the previous cycle
   a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_rd) |-> (reg_rdata == '0));
endmodule

bind xirq_router xirq_router_chk #(.NUM_VEC(NUM_VEC), .CORES(CORES), .PINS(PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .irq_in(irq_in), .pend(pend_q), .en(en_bits), .core_irq(core_irq));

// File: tb/xirq_router_tb.sv
module xirq_router_tb;
   localparam int NV = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    node_id = 4'd5;
   logic [NV-1:0] irq_in = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [12:0]   reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [7:0]    reg_be = '0;
   logic [63:0]   reg_rdata;
   logic [31:0]   core_irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   xirq_router #(.NUM_VEC(NV), .CORES(4), .PINS(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .node_id(node_id), .irq_in(irq_in), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
      .reg_rdata(reg_rdata), .core_irq(core_irq));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [63:0] d, input logic [7:0] be);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic rd_chk(input logic [12:0] a, input logic [63:0] exp, input string req);
      logic [63:0] d;
      rd(a, d);
      chk(d == exp, req, d, exp);
   endtask

   // stimulus pattern computed from the requirement encodings
   function automatic logic [3:0] node_of(input int v);
      return (v % 5 == 0) ? 4'd3 : 4'd5;
   endfunction
   function automatic logic [3:0] cores_of(input int v);
      return (v % 9 == 0) ? 4'hF : 4'(1 << (v % 4));
   endfunction
   function automatic bit en_of(input int v);
      return (v % 7) != 3;
   endfunction
   function automatic logic [7:0] psel_of(input int g);
      case (g)
         0: return 8'h02;
         1: return 8'h04;
         2: return 8'h08;
         default: return 8'h81;
      endcase
   endfunction
   function automatic logic [31:0] exp_pins(input int v);
      logic [31:0] r = '0;
      if (en_of(v) && node_of(v) == 4'd5)
         for (int c = 0; c < 4; c++)
            if (cores_of(v)[c]) r[c*8 +: 8] = psel_of(v / 32);
      return r;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(core_irq == 0, "R1 pins", 64'(core_irq), 0);
      rd_chk(13'h1600, 0, "R1 enable");
      rd_chk(13'h1C08, 0, "R1 route");
      rd_chk(13'h14C0, 0, "R1 pin select");
      rd_chk(13'h1680, 0, "R1 bounce");
      rd_chk(13'h1800, 0, "R1 pending");

      // R5: pending but nothing enabled or routed
      @(negedge clk) irq_in[3] = 1'b1;
      @(negedge clk) irq_in[3] = 1'b0;
      @(negedge clk);
      chk(core_irq == 0, "R5 disabled no pin", 64'(core_irq), 0);
      rd_chk(13'h1800, 64'h8, "R5 stays pending");
      wr(13'h1800, 64'h8, 8'hFF);

      // R10: rdata idle after a non-read cycle
      @(negedge clk);
      chk(reg_rdata == 0, "R10 rdata idle", reg_rdata, 0);

      // program routing for the sweep
      wr(13'h14C0, {32'd0, psel_of(3), psel_of(2), psel_of(1), psel_of(0)}, 8'h0F);
      rd_chk(13'h14C0, 64'h81080402, "R7 pin select readback");
      for (int w = 0; w < NV / 8; w++) begin
         logic [63:0] rw;
         for (int l = 0; l < 8; l++) rw[l*8 +: 8] = {node_of(w*8+l), cores_of(w*8+l)};
         wr(13'h1C00 + 13'(w*8), rw, 8'hFF);
      end
      for (int w = 0; w < NV / 64; w++) begin
         logic [63:0] ew;
         for (int b = 0; b < 64; b++) ew[b] = en_of(w*64+b);
         wr(13'h1600 + 13'(w*8), ew, 8'hFF);
      end

      // R2 R6 R7 R5 R3: sweep every vector
      for (int v = 0; v < NV; v++) begin
         logic [12:0] pa;
         pa = 13'h1800 + 13'((v / 64) * 8);
         @(negedge clk) irq_in[v] = 1'b1;
         @(negedge clk) irq_in[v] = 1'b0;
         @(negedge clk);
         chk(core_irq == exp_pins(v), $sformatf("R6/R7 pins v=%0d", v), 64'(core_irq), 64'(exp_pins(v)));
         rd_chk(pa, 64'd1 << (v % 64), $sformatf("R2 pending v=%0d", v));
         wr(pa, 64'd1 << (v % 64), 8'hFF);
         @(negedge clk);
         chk(core_irq == 0, $sformatf("R3 pins after clear v=%0d", v), 64'(core_irq), 0);
         rd_chk(pa, 0, $sformatf("R3 cleared v=%0d", v));
      end

      // R6: wrong node blocks; changing node_id admits it (v=5 routes to node 3)
      @(negedge clk) irq_in[5] = 1'b1;
      @(negedge clk) irq_in[5] = 1'b0;
      node_id = 4'd3;
      @(negedge clk);
      chk(core_irq == 32'h0000_0200, "R6 node match", 64'(core_irq), 64'h200);
      node_id = 4'd5;
      wr(13'h1800, 64'h20, 8'hFF);

      // R3: byte-enable and zero-data behaviour of the clear
      @(negedge clk) begin irq_in[0] = 1'b1; irq_in[40] = 1'b1; end
      @(negedge clk) begin irq_in[0] = 1'b0; irq_in[40] = 1'b0; end
      wr(13'h1800, 64'h0, 8'hFF);
      rd_chk(13'h1800, 64'h0000_0100_0000_0001, "R3 zero write no effect");
      wr(13'h1800, '1, 8'h0F);
      rd_chk(13'h1800, 64'h0000_0100_0000_0000, "R3 byte enables");
      wr(13'h1800, '1, 8'hFF);

      // R4: edge and clear in the same cycle
      @(negedge clk);
      irq_in[10] = 1'b1;
      reg_wr = 1'b1; reg_addr = 13'h1800; reg_wdata = 64'h400; reg_be = 8'hFF;
      @(negedge clk);
      reg_wr = 1'b0; irq_in[10] = 1'b0;
      rd_chk(13'h1800, 64'h400, "R4 set wins");
      wr(13'h1800, 64'h400, 8'hFF);

      // R2: held level does not re-set after clear
      @(negedge clk) irq_in[70] = 1'b1;
      @(negedge clk);
      wr(13'h1808, 64'h40, 8'hFF);
      repeat (3) @(negedge clk);
      rd_chk(13'h1808, 0, "R2 level no re-set");
      irq_in[70] = 1'b0;

      // R8: bounce and node-map storage
      wr(13'h1688, 64'h1122_3344_5566_7788, 8'hF0);
      rd_chk(13'h1688, 64'h1122_3344_0000_0000, "R8 bounce byte enables");
      wr(13'h14A8, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF);
      rd_chk(13'h14A8, 64'hDEAD_BEEF_0BAD_F00D, "R8 node map");

      // R9: unmapped offsets
      wr(13'h1000, '1, 8'hFF);
      rd_chk(13'h1000, 0, "R9 unmapped read");
      rd_chk(13'h1610, 0, "R9 beyond enable");
      rd_chk(13'h1C80, 0, "R9 beyond route");
      wr(13'h1810, '1, 8'hFF);
      rd_chk(13'h1810, 0, "R9 beyond pending");
      rd_chk(13'h1600, 64'hF7EF_DFBF_7EFD_FBF7, "R9 enable unchanged");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule